// File: doc/BRIEF.md
# Gshare Branch Direction Predictor

This block guesses the direction of conditional branches for a fetch stage. It keeps a table of small saturating counters. The table is addressed by the exclusive-OR of a slice of the fetch address and a register holding the outcomes of the most recent branches. Because the address is mixed with recent outcome history, one static branch can use different counters depending on the path that led to it. The prediction is purely combinational: a fetch address presented in a cycle yields its taken/not-taken guess in that same cycle. The current history is also returned, so the front end can carry it down the pipeline as a snapshot.

When a branch resolves, the back end returns the branch address, the real outcome, the history snapshot taken at prediction time and a flag that marks a wrong guess. The counter that made the guess is retrained at the same index used to read it. The outcome is then shifted into the history. On a wrong guess, the history is first rebuilt from the snapshot, so the younger speculative outcomes are discarded.

Top module: `gshare_predictor`

## Requirements
- R1: After reset every counter holds the weakly-not-taken value (binary 01 for 2-bit counters), so every address predicts not-taken, and the history register reads zero.
- R2: `pred_taken` equals the most significant bit of the counter at index `pred_pc[9:2] XOR pred_hist`, in the same cycle; address bits outside [9:2] have no effect.
- R3: An update with `upd_taken`=1 increments the addressed counter by one, saturating at the all-ones value (3).
- R4: An update with `upd_taken`=0 decrements the addressed counter by one, saturating at zero.
- R5: A counter at its strongly-taken value (3) still predicts taken after one not-taken update, and predicts not-taken after the second consecutive one.
- R6: Training uses index `upd_pc[9:2] XOR upd_hist`, not the live history; the entry selected by the live history is left untouched.
- R7: An update with `upd_mispred`=0 sets the history to `{history[6:0], upd_taken}` on the next clock edge.
- R8: An update with `upd_mispred`=1 sets the history to `{upd_hist[6:0], upd_taken}` on the next clock edge, whatever the live history was.
- R9: When a prediction and an update address the same entry in one cycle, the prediction returns the value before the update; the new value is visible from the next cycle.
- R10: While `upd_valid` is 0, the history and every counter keep their values, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | PC_W | Fetch address to predict |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_W | Live global history, to be kept as the snapshot |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome, 1 = taken |
| upd_hist | input | HIST_W | History snapshot captured when the branch was predicted |
| upd_mispred | input | 1 | The earlier guess was wrong; rebuild the history from the snapshot |

## Verification
`pred_taken` and `pred_hist` are combinational from the address and the stored state. They are therefore checked one time unit after the address changes, within the same cycle. Counter and history changes caused by an update appear one cycle after the update is presented. The bench drives each update on a falling edge, lets the rising edge commit it, and drops `upd_valid` on the following falling edge before it checks. For the same-entry case, the bench samples before the committing edge and again after it, and it expects the old and the new value.

// File: rtl/gsp_pkg.sv
package gsp_pkg;
   localparam int GSP_PC_W_DEF   = 32;
   localparam int GSP_HIST_W_DEF = 8;
   localparam int GSP_IDX_W_DEF  = 8;
   localparam int GSP_CTR_W_DEF  = 2;
   localparam int GSP_PC_LSB_DEF = 2;

   typedef enum logic {
      GSP_DIR_NOT_TAKEN = 1'b0,
      GSP_DIR_TAKEN     = 1'b1
   } gsp_dir_e;
endpackage

// File: rtl/gsp_index.sv
module gsp_index #(
   parameter int PC_W   = gsp_pkg::GSP_PC_W_DEF,
   parameter int HIST_W = gsp_pkg::GSP_HIST_W_DEF,
   parameter int IDX_W  = gsp_pkg::GSP_IDX_W_DEF,
   parameter int PC_LSB = gsp_pkg::GSP_PC_LSB_DEF
) (
   input  logic [PC_W-1:0]   pc,
   input  logic [HIST_W-1:0] hist,
   output logic [IDX_W-1:0]  idx
);
   logic [IDX_W-1:0] pc_slice;
   assign pc_slice = pc[PC_LSB +: IDX_W];

   generate
      if (HIST_W == IDX_W) begin : g_full
         assign idx = pc_slice ^ hist;
      end else begin : g_low
         // shorter history folds into the low index bits only
         assign idx = pc_slice ^ {{(IDX_W-HIST_W){1'b0}}, hist};
      end
   endgenerate

   logic unused_pc;
   assign unused_pc = ^{pc[PC_W-1:PC_LSB+IDX_W], pc[PC_LSB-1:0]};
endmodule

// File: rtl/gsp_sat_ctr.sv
module gsp_sat_ctr #(
   parameter int CTR_W = gsp_pkg::GSP_CTR_W_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  gsp_pkg::gsp_dir_e dir,
   output logic [CTR_W-1:0] val
);
   localparam logic [CTR_W-1:0] CTR_MAX  = {CTR_W{1'b1}};
   localparam logic [CTR_W-1:0] CTR_MIN  = '0;
   localparam logic [CTR_W-1:0] CTR_INIT = CTR_MAX >> 1;

   logic [CTR_W-1:0] val_nx;

   always_comb begin
      val_nx = val;
      if (en) begin
         if (dir == gsp_pkg::GSP_DIR_TAKEN) begin
            if (val != CTR_MAX) val_nx = val + 1'b1;
         end else begin
            if (val != CTR_MIN) val_nx = val - 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) val <= CTR_INIT;
      else        val <= val_nx;
   end
endmodule

// File: rtl/gsp_history.sv
module gsp_history #(
   parameter int HIST_W = gsp_pkg::GSP_HIST_W_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              restore,
   input  logic              bit_in,
   input  logic [HIST_W-1:0] snap,
   output logic [HIST_W-1:0] hist
);
   logic [HIST_W-1:0] base;
   logic [HIST_W-1:0] hist_nx;

   assign base    = restore ? snap : hist;
   assign hist_nx = shift_en ? {base[HIST_W-2:0], bit_in} : hist;

   always_ff @(posedge clk) begin
      if (!rst_n) hist <= '0;
      else        hist <= hist_nx;
   end
endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor #(
   parameter int PC_W   = gsp_pkg::GSP_PC_W_DEF,
   parameter int HIST_W = gsp_pkg::GSP_HIST_W_DEF,
   parameter int IDX_W  = gsp_pkg::GSP_IDX_W_DEF,
   parameter int CTR_W  = gsp_pkg::GSP_CTR_W_DEF,
   parameter int PC_LSB = gsp_pkg::GSP_PC_LSB_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PC_W-1:0]   pred_pc,
   output logic              pred_taken,
   output logic [HIST_W-1:0] pred_hist,
   input  logic              upd_valid,
   input  logic [PC_W-1:0]   upd_pc,
   input  logic              upd_taken,
   input  logic [HIST_W-1:0] upd_hist,
   input  logic              upd_mispred
);
   localparam int DEPTH = 1 << IDX_W;

   if (HIST_W < 2)                  $error("HIST_W must be at least 2");
   if (HIST_W > IDX_W)              $error("HIST_W must not exceed IDX_W");
   if (CTR_W < 2)                   $error("CTR_W must be at least 2");
   if (IDX_W > 12)                  $error("IDX_W too large for a flop table");
   if (PC_LSB < 1)                  $error("PC_LSB must be at least 1");
   if (PC_LSB + IDX_W >= PC_W)      $error("index slice exceeds PC width");

   logic [IDX_W-1:0] rd_idx;
   logic [IDX_W-1:0] wr_idx;
   logic [CTR_W-1:0] ctr_q [DEPTH];
   gsp_pkg::gsp_dir_e upd_dir;

   assign upd_dir = upd_taken ? gsp_pkg::GSP_DIR_TAKEN : gsp_pkg::GSP_DIR_NOT_TAKEN;

   gsp_index #(.PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W), .PC_LSB(PC_LSB)) u_rd_idx (
      .pc   (pred_pc),
      .hist (pred_hist),
      .idx  (rd_idx)
   );

   gsp_index #(.PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W), .PC_LSB(PC_LSB)) u_wr_idx (
      .pc   (upd_pc),
      .hist (upd_hist),
      .idx  (wr_idx)
   );

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic hit;
      assign hit = upd_valid && (wr_idx == IDX_W'(e));
      gsp_sat_ctr #(.CTR_W(CTR_W)) u_ctr (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (hit),
         .dir   (upd_dir),
         .val   (ctr_q[e])
      );
   end

   logic [CTR_W-1:0] rd_val;
   assign rd_val     = ctr_q[rd_idx];
   assign pred_taken = rd_val[CTR_W-1];

   gsp_history #(.HIST_W(HIST_W)) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (upd_valid),
      .restore  (upd_mispred),
      .bit_in   (upd_taken),
      .snap     (upd_hist),
      .hist     (pred_hist)
   );
endmodule

// File: rtl/gsp_checker.sv
module gsp_checker #(
   parameter int PC_W   = 32,
   parameter int HIST_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [PC_W-1:0]   pred_pc,
   input logic              pred_taken,
   input logic [HIST_W-1:0] pred_hist,
   input logic              upd_valid,
   input logic              upd_taken,
   input logic [HIST_W-1:0] upd_hist,
   input logic              upd_mispred
);
   assert_hist_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pred_hist == '0));

   assert_hist_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !upd_mispred) |=>
         (pred_hist == {$past(pred_hist[HIST_W-2:0]), $past(upd_taken)}));

   assert_hist_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_mispred) |=>
         (pred_hist == {$past(upd_hist[HIST_W-2:0]), $past(upd_taken)}));

   assert_hist_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_valid |=> $stable(pred_hist));

   assert_pred_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_valid |=> (!$stable(pred_pc) || $stable(pred_taken)));
endmodule

bind gshare_predictor gsp_checker #(.PC_W(PC_W), .HIST_W(HIST_W)) u_gsp_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pred_pc     (pred_pc),
   .pred_taken  (pred_taken),
   .pred_hist   (pred_hist),
   .upd_valid   (upd_valid),
   .upd_taken   (upd_taken),
   .upd_hist    (upd_hist),
   .upd_mispred (upd_mispred)
);

// File: tb/sim_gshare_predictor.sv
module sim_gshare_predictor;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG_CYCLES = 200000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pred_pc = '0;
   logic        pred_taken;
   logic [7:0]  pred_hist;
   logic        upd_valid = 1'b0;
   logic [31:0] upd_pc = '0;
   logic        upd_taken = 1'b0;
   logic [7:0]  upd_hist = '0;
   logic        upd_mispred = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   int       ref_ctr [256];
   logic [7:0] ref_hist;

   always #(CLK_PERIOD/2) clk = ~clk;

   gshare_predictor u0 (
      .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
      .pred_hist(pred_hist), .upd_valid(upd_valid), .upd_pc(upd_pc),
      .upd_taken(upd_taken), .upd_hist(upd_hist), .upd_mispred(upd_mispred)
   );

   function automatic logic [31:0] pc_for(input logic [7:0] idx, input logic [7:0] h);
      return {22'h2A5A5, idx ^ h, 2'b11};
   endfunction

   task automatic chk_bit(input logic got, input logic exp, input string req);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0b expected=%0b", req, got, exp);
      end
   endtask

   task automatic chk_hist(input logic [7:0] exp, input string req);
      checks++;
      if (pred_hist !== exp) begin
         errors++;
         $display("FAIL %s: history actual=%02h expected=%02h", req, pred_hist, exp);
      end
   endtask

   // prediction for a table entry, addressed through the live history
   task automatic chk_entry(input logic [7:0] idx, input string req);
      pred_pc = pc_for(idx, ref_hist);
      #1;
      chk_bit(pred_taken, ref_ctr[idx] >= 2, req);
   endtask

   task automatic model_upd(input logic [31:0] pc, input logic t, input logic [7:0] h, input logic m);
      logic [7:0] idx;
      idx = pc[9:2] ^ h;
      if (t && ref_ctr[idx] < 3) ref_ctr[idx]++;
      if (!t && ref_ctr[idx] > 0) ref_ctr[idx]--;
      ref_hist = m ? {h[6:0], t} : {ref_hist[6:0], t};
   endtask

   task automatic do_upd(input logic [31:0] pc, input logic t, input logic [7:0] h, input logic m);
      @(negedge clk);
      upd_valid = 1'b1; upd_pc = pc; upd_taken = t; upd_hist = h; upd_mispred = m;
      @(negedge clk);
      upd_valid = 1'b0;
      model_upd(pc, t, h, m);
   endtask

   // train entry idx through the live history, no mispredict
   task automatic train(input logic [7:0] idx, input logic t);
      do_upd(pc_for(idx, ref_hist), t, ref_hist, 1'b0);
   endtask

   task automatic t_reset;
      chk_hist(8'h00, "R1 reset history");
      for (int i = 0; i < 256; i += 37) chk_entry(8'(i), "R1 reset counter weakly not-taken");
   endtask

   task automatic t_index;
      train(8'h10, 1'b1);
      train(8'h10, 1'b1);
      pred_pc = {22'h3FFFF, 8'h10 ^ ref_hist, 2'b00};
      #1; chk_bit(pred_taken, 1'b1, "R2 upper/lower pc bits ignored, taken entry");
      pred_pc = {22'h00001, 8'h10 ^ ref_hist, 2'b10};
      #1; chk_bit(pred_taken, 1'b1, "R2 other outer bits, same entry");
      chk_entry(8'h11, "R2 neighbour entry untouched");
   endtask

   task automatic t_inc_sat;
      train(8'h20, 1'b1);
      chk_entry(8'h20, "R3 1->2 predicts taken");
      train(8'h20, 1'b1);
      train(8'h20, 1'b1);
      train(8'h20, 1'b1);
      train(8'h20, 1'b0);
      chk_entry(8'h20, "R3 saturated at 3, one decrement stays taken");
   endtask

   task automatic t_flip;
      train(8'h30, 1'b1);
      train(8'h30, 1'b1);
      chk_entry(8'h30, "R5 strong taken");
      train(8'h30, 1'b0);
      chk_entry(8'h30, "R5 after one not-taken still taken");
      train(8'h30, 1'b0);
      chk_entry(8'h30, "R5 after two not-taken flips");
   endtask

   task automatic t_dec_sat;
      train(8'h40, 1'b0);
      train(8'h40, 1'b0);
      train(8'h40, 1'b0);
      chk_entry(8'h40, "R4 floor at 0");
      train(8'h40, 1'b1);
      chk_entry(8'h40, "R4 0->1 still not-taken");
      train(8'h40, 1'b1);
      chk_entry(8'h40, "R4 1->2 taken, no wrap at floor");
   endtask

   task automatic t_snapshot;
      logic [7:0] snap;
      logic [7:0] live;
      snap = 8'h5A;
      live = ref_hist;
      if (live == snap) snap = 8'hA5;
      do_upd({22'h0, 8'h11, 2'b00}, 1'b1, snap, 1'b0);
      chk_entry(8'h11 ^ snap, "R6 entry selected by snapshot trained");
      chk_entry(8'h11 ^ live, "R6 entry selected by live history untouched");
   endtask

   task automatic t_shift;
      logic [7:0] exp;
      exp = ref_hist;
      for (int i = 0; i < 5; i++) begin
         do_upd(32'h0000_1000 + 32'(i*4), 1'(i % 2), 8'hFF, 1'b0);
         exp = {exp[6:0], 1'(i % 2)};
         chk_hist(exp, "R7 history shift on correct prediction");
      end
   endtask

   task automatic t_restore;
      do_upd(32'h0000_2000, 1'b0, 8'hC3, 1'b1);
      chk_hist(8'h86, "R8 restore snapshot C3 with not-taken");
      do_upd(32'h0000_2004, 1'b1, 8'h00, 1'b1);
      chk_hist(8'h01, "R8 restore snapshot 00 with taken");
   endtask

   task automatic t_same_cycle;
      @(negedge clk);
      upd_valid = 1'b1; upd_pc = pc_for(8'h77, ref_hist); upd_taken = 1'b1;
      upd_hist = ref_hist; upd_mispred = 1'b0;
      pred_pc = pc_for(8'h77, ref_hist);
      #1;
      chk_bit(pred_taken, 1'b0, "R9 same-cycle read returns old value");
      @(negedge clk);
      upd_valid = 1'b0;
      model_upd(upd_pc, 1'b1, upd_hist, 1'b0);
      chk_entry(8'h77, "R9 new value visible next cycle");
   endtask

   task automatic t_idle;
      logic [7:0] h0;
      h0 = ref_hist;
      @(negedge clk);
      upd_pc = pc_for(8'h20, ref_hist); upd_taken = 1'b0; upd_hist = ref_hist; upd_mispred = 1'b1;
      repeat (6) @(negedge clk);
      chk_hist(h0, "R10 history held while upd_valid low");
      chk_entry(8'h20, "R10 counter held while upd_valid low");
      upd_mispred = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < 256; i++) ref_ctr[i] = 1;
      ref_hist = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_index();
      t_inc_sat();
      t_flip();
      t_dec_sat();
      t_snapshot();
      t_shift();
      t_restore();
      t_same_cycle();
      t_idle();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * WATCHDOG_CYCLES);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog (all requirements): actual=expired expected=complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule